// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block is a synchronous controller for an external asynchronous static RAM of 524,288 byte-wide locations, with 19 address lines and 8 data lines. On the internal side a single request port accepts a read or write with a valid/ready handshake. A read returns its byte with a one-cycle valid strobe. On the external side the block drives the address, three active-low strobes (chip select, output enable and write strobe) and an 8-bit data bus. The bus is split into an outgoing value, an incoming value and a drive enable.

Every access is built from whole clock cycles. The minimum read window, write-strobe width, data setup time and bus release time are given in nanoseconds as parameters. The clock period is also a parameter. Each time is rounded up to a cycle count. The address is held in a register that only loads while chip select is high, so it never moves during an access. The controller never drives the bus while output enable is low. After a read, a counted gap lets the memory release the bus before the controller drives it again.

The state machine has six states. IDLE accepts a request. READ_WAIT holds the read window. WRITE_SETUP drives data with the write strobe high. WRITE_PULSE holds the write strobe low. WRITE_HOLD raises the write strobe while data is still driven. TURNAROUND waits for the bus to be released after a read. The transitions are: IDLE to READ_WAIT on an accepted read. IDLE to WRITE_SETUP on an accepted write when no gap is pending. IDLE to TURNAROUND on an accepted write when a gap is pending. READ_WAIT to IDLE when its window ends. TURNAROUND to WRITE_SETUP when the gap ends. WRITE_SETUP to WRITE_PULSE after one cycle. WRITE_PULSE to WRITE_HOLD when the pulse ends. WRITE_HOLD to IDLE after one cycle.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the controller is in IDLE. In that state `req_ready` is 1, all three strobes are high (inactive), `sram_dq_oe` is 0 and `rd_valid` is 0.
- R2: `req_ready` is 1 only in IDLE, and only while chip select is high. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_write` = 1 means a write and 0 means a read.
- R3: A read holds chip select and output enable low, with the write strobe high, for exactly RC_CYC = ceil(T_RC/CLK_NS) cycles (6 with the defaults). The read captures `sram_dq_in` at the end of the last of those cycles. It presents the byte on `rd_data` with `rd_valid` high for exactly one cycle, RC_CYC+1 cycles after the accepting edge. Bus values seen earlier in the window are ignored.
- R4: A write is one WRITE_SETUP cycle (data driven, write strobe high), then WP_CYC cycles with the write strobe low, then one WRITE_HOLD cycle (write strobe high, data still driven). After that the drive is released. WP_CYC is the largest of ceil(T_WP/CLK_NS), ceil(T_DW/CLK_NS) and RC_CYC-2, which is 5 with the defaults.
- R5: Output enable stays high for the whole of a write. `sram_dq_oe` is never 1 while output enable is low.
- R6: After a read, the data drive is not enabled until output enable has been high for at least TURN_CYC = ceil(T_TURN/CLK_NS) cycles (2 with the defaults). A write accepted with no gap pending drives from the first cycle after acceptance.
- R7: `sram_addr` does not change while chip select stays low between two consecutive cycles.
- R8: Whenever chip select is high, the write strobe and output enable are high and `sram_dq_oe` is 0.
- R9: A read returns the byte most recently written to the same address, at any address in the full range, including 0 and 0x7FFFF. It also returns the value after an overwrite.
- R10: A reset during an access returns all strobes high and `req_ready` to 1 by the next cycle. The aborted read produces no `rd_valid`, and no turnaround gap remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 8 | Read result byte |
| sram_addr | output | 19 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_out | output | 8 | Data the controller drives |
| sram_dq_in | input | 8 | Data from the memory |
| sram_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The bench builds the controller with an 8 ns clock and 45/35/20/15 ns timings. These give a 6-cycle read window and a 5-cycle write strobe, where the strobe width rather than the data setup time sets the pulse. They also give a 2-cycle bus gap, so the TURNAROUND state is actually entered when a write follows a read at once. The memory model returns a poison byte until the sixth cycle of a read. It checks strobe width, data stability, address stability and bus contention cycle by cycle, so a shortened window or a missing gap shows up as a wrong byte or a flagged violation.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_WAIT,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_HOLD,
        ST_TURNAROUND
    } seq_state_e;

    // Nanoseconds to whole cycles, rounding up; never below one cycle.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
// Loadable down counter that stops at zero.
module sram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign zero = (count == '0);
endmodule

// File: rtl/sram_seq_datapath.sv
// Request registers and read-result capture.
module sram_seq_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rd_data <= bus_in;
        end
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int CLK_NS = 8,
    parameter int T_RC   = 45,
    parameter int T_WP   = 35,
    parameter int T_DW   = 20,
    parameter int T_TURN = 15,
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);
    localparam int RC_CYC   = ns_to_cyc(T_RC, CLK_NS);
    localparam int WP_CYC   = max3(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_DW, CLK_NS), RC_CYC - 2);
    localparam int TURN_CYC = ns_to_cyc(T_TURN, CLK_NS);
    localparam int CNT_W    = $clog2(max3(RC_CYC, WP_CYC, TURN_CYC) + 1);

    seq_state_e state, state_nx;

    logic             accept;
    logic             acc_load, acc_zero;
    logic [CNT_W-1:0] acc_val, acc_cnt;
    logic             turn_load, turn_zero, turn_clear;
    logic [CNT_W-1:0] turn_cnt;
    logic             read_done;

    assign accept    = req_valid && req_ready;
    assign read_done = (state == ST_READ_WAIT) && acc_zero;
    // Gap is over once at most one more high-OE cycle is owed (the current one counts).
    assign turn_clear = turn_zero || (turn_cnt == CNT_W'(1));

    // Access window timer: read window or write strobe width.
    assign acc_load = (accept && !req_write) || (state == ST_WRITE_SETUP);
    assign acc_val  = (state == ST_WRITE_SETUP) ? CNT_W'(WP_CYC - 1) : CNT_W'(RC_CYC - 1);

    sram_seq_timer #(.CNT_W(CNT_W)) u_acc_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (acc_load),
        .load_val (acc_val),
        .count    (acc_cnt),
        .zero     (acc_zero)
    );

    // Bus release gap, started as a read window closes.
    assign turn_load = read_done;

    sram_seq_timer #(.CNT_W(CNT_W)) u_turn_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (turn_load),
        .load_val (CNT_W'(TURN_CYC)),
        .count    (turn_cnt),
        .zero     (turn_zero)
    );

    sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (read_done),
        .bus_in    (sram_dq_in),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_out),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write)
                        state_nx = ST_READ_WAIT;
                    else if (turn_clear)
                        state_nx = ST_WRITE_SETUP;
                    else
                        state_nx = ST_TURNAROUND;
                end
            end
            ST_READ_WAIT:   if (acc_zero) state_nx = ST_IDLE;
            ST_TURNAROUND:  if (turn_clear) state_nx = ST_WRITE_SETUP;
            ST_WRITE_SETUP: state_nx = ST_WRITE_PULSE;
            ST_WRITE_PULSE: if (acc_zero) state_nx = ST_WRITE_HOLD;
            ST_WRITE_HOLD:  state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    // Strobes and drive enable, decoded from the state
    always_comb begin
        req_ready  = 1'b0;
        sram_ce_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE:        req_ready = 1'b1;
            ST_READ_WAIT: begin
                sram_ce_n = 1'b0;
                sram_oe_n = 1'b0;
            end
            ST_TURNAROUND:  ;
            ST_WRITE_SETUP: begin
                sram_ce_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WRITE_PULSE: begin
                sram_ce_n  = 1'b0;
                sram_we_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WRITE_HOLD: begin
                sram_ce_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^acc_cnt;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int ADDR_W   = 19,
    parameter int WP_CYC   = 5,
    parameter int TURN_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe
);
    logic [7:0] we_low_cnt;
    logic [7:0] oe_high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt  <= 8'd0;
            oe_high_cnt <= 8'hFF;
        end else begin
            we_low_cnt  <= !sram_we_n ? ((we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1) : 8'd0;
            oe_high_cnt <= sram_oe_n ? ((oe_high_cnt == 8'hFF) ? oe_high_cnt : oe_high_cnt + 8'd1) : 8'd0;
        end
    end

    // R8
    idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        sram_ce_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe));

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> !sram_dq_oe);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> sram_ce_n);

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_low_cnt >= 8'(WP_CYC)));

    // R4
    we_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> ($past(sram_dq_oe) && !sram_ce_n));

    // R6
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dq_oe) |-> (oe_high_cnt >= 8'(TURN_CYC)));

    // R3
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;
    localparam int CLK    = 8;
    localparam int RC_EXP = (45 + CLK - 1) / CLK;   // 6
    localparam int WP_EXP = (35 + CLK - 1) / CLK;   // 5
    localparam int DS_EXP = (20 + CLK - 1) / CLK;   // 3
    localparam int TN_EXP = (15 + CLK - 1) / CLK;   // 2
    localparam logic [7:0] POISON = 8'hEE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] sram_addr;
    logic sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_out, sram_dq_in;

    always #4 clk = ~clk;

    sram_seq_ctrl #(.CLK_NS(CLK), .T_RC(45), .T_WP(35), .T_DW(20), .T_TURN(15),
                    .ADDR_W(19), .DATA_W(8)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem [int];
    logic [7:0] dq_in_r = POISON;
    int  acc_cnt = 0, we_cnt = 0, ds_cnt = 0;
    logic prev_we_low = 1'b0, prev_ce_low = 1'b0, last_oe = 1'b0;
    logic [7:0]  last_dout = '0;
    logic [18:0] prev_addr = '0;

    assign sram_dq_in = dq_in_r;

    function automatic logic [7:0] peek(input logic [18:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst) begin
            if (!sram_oe_n && sram_dq_oe)
                chk(0, "R5", "bus contention", 1, 0);
            if (sram_ce_n && (!sram_we_n || !sram_oe_n || sram_dq_oe))
                chk(0, "R8", "strobe while deselected", 1, 0);
            if (!sram_ce_n && prev_ce_low && sram_addr != prev_addr)
                chk(0, "R7", "address moved under select", int'(sram_addr), int'(prev_addr));
            if (prev_we_low && sram_we_n) begin
                if (we_cnt < WP_EXP) chk(0, "R4", "write pulse width", we_cnt, WP_EXP);
                if (ds_cnt < DS_EXP) chk(0, "R4", "data setup cycles", ds_cnt, DS_EXP);
                mem[int'(prev_addr)] = last_dout;
            end
        end
        if (!sram_ce_n && !sram_oe_n) begin
            acc_cnt <= acc_cnt + 1;
            dq_in_r <= (acc_cnt + 1 >= RC_EXP - 1) ? peek(sram_addr) : POISON;
        end else begin
            acc_cnt <= 0;
            dq_in_r <= POISON;
        end
        we_cnt <= (!sram_ce_n && !sram_we_n) ? we_cnt + 1 : 0;
        if (sram_dq_oe)
            ds_cnt <= (last_oe && sram_dq_out == last_dout) ? ds_cnt + 1 : 1;
        else
            ds_cnt <= 0;
        prev_we_low <= !sram_ce_n && !sram_we_n;
        prev_ce_low <= !sram_ce_n;
        prev_addr   <= sram_addr;
        last_dout   <= sram_dq_out;
        last_oe     <= sram_dq_oe;
    end

    // ---------------- access task (called at a negedge) ----------------
    int n_oe_low, n_we_low, n_drive, n_busy, n_addr_ok, lat_rv, first_drive, n_oe_low_w;
    logic [7:0] got;

    task automatic run_op(input bit w, input logic [18:0] a, input logic [7:0] d);
        bit seen_rv;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_oe_low = 0; n_we_low = 0; n_drive = 0; n_busy = 0; n_addr_ok = 0;
        lat_rv = -1; first_drive = -1; n_oe_low_w = 0; seen_rv = 0; got = '0;
        for (int k = 1; k < 40; k++) begin
            if (!sram_oe_n) n_oe_low++;
            if (!sram_oe_n && sram_dq_oe) n_oe_low_w++;
            if (!sram_we_n) n_we_low++;
            if (sram_dq_oe) n_drive++;
            if (sram_dq_oe && first_drive < 0) first_drive = k;
            if (!req_ready) n_busy++;
            if (!sram_ce_n && sram_addr == a) n_addr_ok++;
            if (rd_valid) begin
                if (!seen_rv) begin lat_rv = k; got = rd_data; end
                seen_rv = 1;
            end
            if (req_ready && (w || seen_rv)) break;
            @(negedge clk);
        end
    endtask

    // Stimulus/expected table: {write, addr, data}; for reads data is the expected byte.
    localparam int NV = 13;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 19'h00000, 8'hA5},
        {1'b1, 19'h7FFFF, 8'h3C},
        {1'b0, 19'h00000, 8'hA5},
        {1'b0, 19'h7FFFF, 8'h3C},
        {1'b1, 19'h12345, 8'h5A},
        {1'b1, 19'h12345, 8'hC3},
        {1'b0, 19'h12345, 8'hC3},
        {1'b0, 19'h00001, 8'h00},
        {1'b1, 19'h40000, 8'hFF},
        {1'b0, 19'h40000, 8'hFF},
        {1'b1, 19'h2AAAA, 8'h00},
        {1'b0, 19'h2AAAA, 8'h00},
        {1'b0, 19'h7FFFF, 8'h3C}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        chk({sram_ce_n, sram_oe_n, sram_we_n} == 3'b111, "R1", "strobes in reset",
            {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        chk(!sram_dq_oe && !rd_valid, "R1", "drive/valid in reset", {sram_dq_oe, rd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk (R9)
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][27], VEC[i][26:8], VEC[i][7:0]);
            if (!VEC[i][27])
                chk(got == VEC[i][7:0], "R9", $sformatf("table read %0d", i), got, VEC[i][7:0]);
        end

        // R3/R2 read window shape, after idle cycles
        repeat (4) @(negedge clk);
        run_op(1'b0, 19'h7FFFF, 8'h00);
        chk(n_oe_low == RC_EXP, "R3", "read OE low cycles", n_oe_low, RC_EXP);
        chk(lat_rv == RC_EXP + 1, "R3", "read latency", lat_rv, RC_EXP + 1);
        chk(got == 8'h3C, "R3", "read data captured at window end", got, 8'h3C);
        chk(n_busy == RC_EXP, "R2", "ready low during read", n_busy, RC_EXP);
        chk(n_we_low == 0, "R3", "write strobe during read", n_we_low, 0);
        chk(n_addr_ok == RC_EXP, "R7", "address held during read", n_addr_ok, RC_EXP);

        // R6 write straight after a read: turnaround state
        run_op(1'b1, 19'h00777, 8'h96);
        chk(first_drive == TN_EXP, "R6", "drive start after read", first_drive, TN_EXP);
        chk(n_we_low == WP_EXP, "R4", "write pulse cycles", n_we_low, WP_EXP);
        chk(n_drive == WP_EXP + 2, "R4", "drive cycles", n_drive, WP_EXP + 2);
        chk(n_oe_low == 0, "R5", "OE low during write", n_oe_low, 0);
        chk(n_oe_low_w == 0, "R5", "drive with OE low", n_oe_low_w, 0);

        // R6 write with no gap pending
        repeat (4) @(negedge clk);
        run_op(1'b1, 19'h00778, 8'h69);
        chk(first_drive == 1, "R6", "drive start with no gap", first_drive, 1);
        chk(n_busy == WP_EXP + 2, "R2", "ready low during write", n_busy, WP_EXP + 2);
        run_op(1'b0, 19'h00777, 8'h00);
        chk(got == 8'h96, "R9", "read after turnaround write", got, 8'h96);

        // R9 random read-after-write
        for (int i = 0; i < 20; i++) begin
            logic [18:0] ra;
            logic [7:0]  rd;
            ra = 19'($urandom);
            rd = 8'($urandom);
            run_op(1'b1, ra, rd);
            run_op(1'b0, ra, 8'h00);
            chk(got == rd, "R9", $sformatf("random RAW @%0h", ra), got, rd);
        end

        // R10 reset in the middle of a read
        req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00777;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe} == 4'b1110, "R10", "strobes after reset",
            {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
        chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        rst = 1'b0;
        begin
            int rv_seen;
            rv_seen = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (rd_valid) rv_seen++;
            end
            chk(rv_seen == 0, "R10", "no result from aborted read", rv_seen, 0);
        end
        // Reset right after a read window: no gap may remain
        run_op(1'b0, 19'h00777, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_op(1'b1, 19'h00779, 8'h11);
        chk(first_drive == 1, "R10", "no gap pending after reset", first_drive, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule